// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the winding current of one H-bridge with a fixed off time. A sense comparator outside the block goes high once the coil current climbs above its reference. While the bridge conducts, a qualified comparator trip ends the conduction phase and starts a fixed off interval. A dead interval follows the off interval. The block then asks for conduction again by itself. The gate stage receives a conduction request and an off-phase flag. A single-cycle event pulse marks each chop.

All durations are counted in system clock cycles and set by parameters: the off interval, the dead interval, the blanking window and the minimum conduction time. A duration given as zero behaves as one cycle. The comparator input is asynchronous, so it passes through a flop chain before any decision uses it. For a short window after each turn-on the comparator is masked, so the reverse-recovery spike cannot cut the phase short. A trip that arrives after the mask but before the minimum conduction time is remembered and acted on once that time is reached.

Top module: `chop_regulator`

## Requirements
- R1: While reset is held, and while enable is low after reset, bridge_on, off_phase and chop_pulse are all 0.
- R2: cmp_raw passes through SYNC_STAGES flops (default 2). A level raised on cmp_raw during a long conduction phase clears bridge_on on the third rising edge after it appears (default), not before.
- R3: During the first BLANK_CYCLES cycles of every conduction phase (default 4) the comparator is ignored. A trip seen only in that window leaves bridge_on high and is not remembered.
- R4: A conduction phase ended by the comparator lasts at least MIN_ON_CYCLES cycles (default 6). A trip seen after blanking but earlier is held and ends the phase exactly at that length.
- R5: After a chop, bridge_on stays 0 and off_phase stays 1 for exactly OFF_CYCLES + DEAD_CYCLES cycles (default 10 + 2 = 12). bridge_on and off_phase are never 1 together.
- R6: When the off and dead intervals expire, bridge_on returns to 1 with no other input, and the new phase starts with a fresh blanking window.
- R7: chop_pulse is 1 for exactly one cycle per chop: the first cycle in which off_phase is 1 after a conduction phase.
- R8: When enable is low at a rising edge, the block is idle after that edge with both outputs 0 and all counts cleared. The first edge with enable high starts a fresh conduction phase with blanking and minimum on time.
- R9: A duration parameter of 0 acts as 1 cycle. With all four set to 0 and the comparator held high, conduction lasts 2 cycles and the off span lasts 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator run request; low forces idle |
| cmp_raw | input | 1 | Unsynchronised sense comparator, high when current exceeds reference |
| bridge_on | output | 1 | Conduction request to the gate stage |
| off_phase | output | 1 | High during the off and dead intervals |
| chop_pulse | output | 1 | One-cycle event on each comparator chop |

## Verification
The bound checker watches, on every cycle, that conduction and off phase never overlap and that each event pulse is single and sits on a turn-off. It also checks that a comparator-ended conduction phase is never shorter than the minimum on time, that a completed off span has exactly the programmed length, and that a low enable idles the block at the next edge. The synchroniser latency, the masking of a trip that falls inside the blanking window, the capture of an early trip and its release at the minimum on time, and the zero-to-one clamp depend on what the comparator did, so only the bench scenarios show them. The bench compares both a default and an all-zero instance against a behavioural model on every cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_OFF  = 2'd2,
      ST_DEAD = 2'd3
   } chop_state_t;

   // a duration of zero behaves as one cycle
   function automatic int clamp1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clear)      cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/chop_qualify.sv
module chop_qualify #(
   parameter int W       = 16,
   parameter int BLANK_N = 1,
   parameter int MINON_N = 1
) (
   input  logic [W-1:0] age,
   input  logic         cmp_sync,
   input  logic         on_active,
   input  logic         held,
   output logic         trip,
   output logic         fire
);
   localparam logic [W-1:0] BLANK_T = W'(BLANK_N);
   localparam logic [W-1:0] MINON_T = W'(MINON_N - 1);

   logic minon_ok;

   assign trip = on_active & cmp_sync & (age >= BLANK_T);

   generate
      if (MINON_N <= 1) begin : g_no_min
         assign minon_ok = 1'b1;
      end else begin : g_min
         assign minon_ok = (age >= MINON_T);
      end
   endgenerate

   assign fire = on_active & (trip | held) & minon_ok;
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator #(
   parameter int W             = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int OFF_CYCLES    = 10,
   parameter int DEAD_CYCLES   = 2,
   parameter int BLANK_CYCLES  = 4,
   parameter int MIN_ON_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cmp_raw,
   output logic bridge_on,
   output logic off_phase,
   output logic chop_pulse
);
   import chop_pkg::*;

   localparam int OFF_EFF   = clamp1(OFF_CYCLES);
   localparam int DEAD_EFF  = clamp1(DEAD_CYCLES);
   localparam int BLANK_EFF = clamp1(BLANK_CYCLES);
   localparam int MINON_EFF = clamp1(MIN_ON_CYCLES);
   localparam int CNT_MAX   = (1 << W) - 1;
   localparam logic [W-1:0] OFF_LAST  = W'(OFF_EFF - 1);
   localparam logic [W-1:0] DEAD_LAST = W'(DEAD_EFF - 1);

   generate
      if (W < 2 || W > 30) begin : g_bad_w
         $error("chop_regulator: W must lie in 2..30");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("chop_regulator: SYNC_STAGES must be at least 2");
      end
      if (OFF_EFF > CNT_MAX || DEAD_EFF > CNT_MAX ||
          BLANK_EFF >= CNT_MAX || MINON_EFF >= CNT_MAX) begin : g_bad_len
         $error("chop_regulator: a duration does not fit the counter width");
      end
   endgenerate

   chop_state_t st, nxt;
   logic [W-1:0] age;
   logic         cmp_sync, trip, fire, held, clear;

   chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (cmp_sync)
   );

   chop_timer #(.W(W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .cnt   (age)
   );

   chop_qualify #(.W(W), .BLANK_N(BLANK_EFF), .MINON_N(MINON_EFF)) u_qual (
      .age       (age),
      .cmp_sync  (cmp_sync),
      .on_active (st == ST_ON),
      .held      (held),
      .trip      (trip),
      .fire      (fire)
   );

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: nxt = ST_ON;
         ST_ON:   if (fire)             nxt = ST_OFF;
         ST_OFF:  if (age == OFF_LAST)  nxt = ST_DEAD;
         ST_DEAD: if (age == DEAD_LAST) nxt = ST_ON;
         default: nxt = ST_IDLE;
      endcase
      if (!enable) nxt = ST_IDLE;
   end

   assign clear = (nxt != st) || (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         held       <= 1'b0;
         chop_pulse <= 1'b0;
      end else begin
         st         <= nxt;
         chop_pulse <= (st == ST_ON) && (nxt == ST_OFF);
         if (st != ST_ON || nxt != ST_ON) held <= 1'b0;
         else if (trip)                   held <= 1'b1;
      end
   end

   assign bridge_on = (st == ST_ON);
   assign off_phase = (st == ST_OFF) || (st == ST_DEAD);
endmodule

// File: rtl/chop_regulator_chk.sv
module chop_regulator_chk #(
   parameter int MIN_ON    = 1,
   parameter int OFF_TOTAL = 2
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic bridge_on,
   input logic off_phase,
   input logic chop_pulse
);
   int unsigned on_len, off_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_len  <= 0;
         off_len <= 0;
      end else begin
         on_len  <= bridge_on ? ((on_len == 32'hFFFF_FFFF) ? on_len : on_len + 1) : 0;
         off_len <= off_phase ? ((off_len == 32'hFFFF_FFFF) ? off_len : off_len + 1) : 0;
      end
   end

   assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bridge_on && off_phase));

   assert_off_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_on && off_len != 0) |-> off_len == OFF_TOTAL);

   assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_pulse && on_len != 0) |-> on_len >= MIN_ON);

   assert_pulse_on_turnoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chop_pulse |-> (off_phase && on_len != 0));

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chop_pulse |=> !chop_pulse);

   assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!bridge_on && !off_phase && !chop_pulse));
endmodule

bind chop_regulator chop_regulator_chk #(
   .MIN_ON    (chop_pkg::clamp1(MIN_ON_CYCLES)),
   .OFF_TOTAL (chop_pkg::clamp1(OFF_CYCLES) + chop_pkg::clamp1(DEAD_CYCLES))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .bridge_on  (bridge_on),
   .off_phase  (off_phase),
   .chop_pulse (chop_pulse)
);

// File: tb/chop_regulator_test.sv
`timescale 1ns/1ps

module chop_regulator_model #(
   parameter int OFF_N = 10,
   parameter int DEAD_N = 2,
   parameter int BLANK_N = 4,
   parameter int MINON_N = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cmp,
   output logic m_on,
   output logic m_off,
   output logic m_pulse
);
   int o_n, d_n, b_n, mo_n;
   int phase = 0;   // 0 idle, 1 conducting, 2 off, 3 dead
   int age = 0, rem = 0;
   bit pend = 0, s1 = 0, s2 = 0, seen, hit, pulse = 0;

   initial begin
      o_n  = (OFF_N   < 1) ? 1 : OFF_N;
      d_n  = (DEAD_N  < 1) ? 1 : DEAD_N;
      b_n  = (BLANK_N < 1) ? 1 : BLANK_N;
      mo_n = (MINON_N < 1) ? 1 : MINON_N;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase = 0; age = 0; rem = 0; pend = 0; s1 = 0; s2 = 0; pulse = 0;
      end else begin
         seen = s2; s2 = s1; s1 = cmp;
         pulse = 0;
         if (!en) begin
            phase = 0; age = 0; pend = 0;
         end else if (phase == 0) begin
            phase = 1; age = 0; pend = 0;
         end else if (phase == 1) begin
            hit = seen && (age >= b_n);
            if ((hit || pend) && age >= mo_n - 1) begin
               phase = 2; rem = o_n; pulse = 1; pend = 0;
            end else begin
               if (hit) pend = 1;
               age++;
            end
         end else if (phase == 2) begin
            rem--;
            if (rem == 0) begin phase = 3; rem = d_n; end
         end else begin
            rem--;
            if (rem == 0) begin phase = 1; age = 0; end
         end
      end
   end

   assign m_on    = (phase == 1);
   assign m_off   = (phase == 2) || (phase == 3);
   assign m_pulse = pulse;
endmodule

module chop_regulator_test;
   logic clk = 0, rst_n = 0, enable = 0, cmp_raw = 0;
   logic bridge_on, off_phase, chop_pulse;
   logic z_on, z_off, z_pulse;
   logic m_on, m_off, m_pulse, mz_on, mz_off, mz_pulse;
   int checks = 0, failures = 0;
   bit live = 0, done = 0;

   always #2.5 clk = ~clk;

   chop_regulator uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_raw(cmp_raw),
      .bridge_on(bridge_on), .off_phase(off_phase), .chop_pulse(chop_pulse));

   chop_regulator #(.OFF_CYCLES(0), .DEAD_CYCLES(0), .BLANK_CYCLES(0),
                    .MIN_ON_CYCLES(0)) uut_zero (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_raw(cmp_raw),
      .bridge_on(z_on), .off_phase(z_off), .chop_pulse(z_pulse));

   chop_regulator_model ref_main (
      .clk(clk), .rst_n(rst_n), .en(enable), .cmp(cmp_raw),
      .m_on(m_on), .m_off(m_off), .m_pulse(m_pulse));

   chop_regulator_model #(.OFF_N(0), .DEAD_N(0), .BLANK_N(0), .MINON_N(0)) ref_zero (
      .clk(clk), .rst_n(rst_n), .en(enable), .cmp(cmp_raw),
      .m_on(mz_on), .m_off(mz_off), .m_pulse(mz_pulse));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // every-cycle comparison against the behavioural model (R5 R6 R7 R9)
   always @(negedge clk) begin
      if (live) begin
         check("R6 bridge_on vs model", bridge_on, m_on);
         check("R5 off_phase vs model", off_phase, m_off);
         check("R7 chop_pulse vs model", chop_pulse, m_pulse);
         check("R9 zero bridge_on vs model", z_on, mz_on);
         check("R9 zero off_phase vs model", z_off, mz_off);
         check("R9 zero chop_pulse vs model", z_pulse, mz_pulse);
      end
   end

   initial begin
      #(5.0 * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int n;
      int pulses;
      bit ok;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 bridge_on in reset", bridge_on, 0);
      check("R1 off_phase in reset", off_phase, 0);
      check("R1 chop_pulse in reset", chop_pulse, 0);
      rst_n = 1;
      live = 1;
      repeat (3) step();
      check("R1 idle bridge_on with enable low", bridge_on, 0);
      check("R1 idle off_phase with enable low", off_phase, 0);

      // start conduction
      enable = 1;
      step();
      check("R8 conduction starts after enable", bridge_on, 1);

      // R3: trip inside the blanking window is ignored
      cmp_raw = 1;
      step(); step();
      cmp_raw = 0;
      ok = 1;
      for (int i = 0; i < 20; i++) begin
         step();
         if (!bridge_on) ok = 0;
      end
      check("R3 blanked trip ignored", ok, 1);

      // R2: synchroniser latency
      cmp_raw = 1;
      step();
      check("R2 still on after first edge", bridge_on, 1);
      step();
      check("R2 still on after second edge", bridge_on, 1);
      step();
      check("R2 off after third edge", bridge_on, 0);
      check("R7 pulse on first off cycle", chop_pulse, 1);
      check("R5 off_phase on first off cycle", off_phase, 1);

      // R5: off span length (comparator kept high from here)
      n = 1;
      for (int i = 0; i < 100; i++) begin
         step();
         if (i == 0) check("R7 pulse lasts one cycle", chop_pulse, 0);
         if (off_phase) n++;
         else break;
      end
      check("R5 off span length", n, 12);
      check("R6 automatic restart", bridge_on, 1);

      // R4: early trip held until minimum on time
      n = 1;
      for (int i = 0; i < 100; i++) begin
         step();
         if (bridge_on) n++;
         else break;
      end
      check("R4 conduction length with early trip", n, 6);
      check("R6 restarted phase chopped again", chop_pulse, 1);

      // R7: pulse count over two periods (6 + 12)
      pulses = 0;
      for (int i = 0; i < 36; i++) begin
         step();
         if (chop_pulse) pulses++;
      end
      check("R7 pulses in two periods", pulses, 2);

      // R9: zero-parameter instance, comparator held high
      for (int i = 0; i < 10; i++) begin
         if (!z_on) step();
      end
      for (int i = 0; i < 10; i++) begin
         if (z_on) step();
      end
      for (int i = 0; i < 10; i++) begin
         if (!z_on) step();
      end
      n = 0;
      for (int i = 0; i < 10; i++) begin
         if (z_on) begin n++; step(); end
      end
      check("R9 clamped conduction length", n, 2);
      n = 0;
      for (int i = 0; i < 10; i++) begin
         if (z_off) begin n++; step(); end
      end
      check("R9 clamped off span", n, 2);

      // R8: disable during the off span
      for (int i = 0; i < 40; i++) begin
         if (!off_phase) step();
      end
      enable = 0;
      step();
      check("R8 idle bridge_on after disable", bridge_on, 0);
      check("R8 idle off_phase after disable", off_phase, 0);
      step();
      enable = 1;
      step();
      check("R8 fresh conduction on re-enable", bridge_on, 1);
      n = 1;
      for (int i = 0; i < 100; i++) begin
         step();
         if (bridge_on) n++;
         else break;
      end
      check("R8 fresh phase honours blank and min on", n, 6);

      // R8: disable during conduction
      for (int i = 0; i < 40; i++) begin
         if (!bridge_on) step();
      end
      enable = 0;
      step();
      check("R8 disable ends conduction", bridge_on, 0);
      cmp_raw = 0;
      repeat (4) step();
      check("R1 stays idle with enable low", off_phase, 0);
      live = 0;
      finish_run();
   end
endmodule